// File: doc/BRIEF.md
# Sleep State Power Controller

This block holds the system power state (working, suspend-to-disk, soft-off) and drives two active-low sleep outputs that the board uses to switch its rails. Software puts the system to sleep by loading a sleep type and then strobing an enable. A power button held past a tick threshold, a thermal trip, a watchdog timeout or a management shutdown request force soft-off. Each of these paths has its own grace level and its own priority.

A separate wake-qualification block presents qualified wake pulses. A wake returns the system to working and sets a sticky status bit. While the battery-low input is high, wakes are held back and remembered. When main power drops, the block records the state it was in. When power returns, a policy input picks either a return to working or a return to the recorded sleep state. The block also reports whether the last entry into soft-off was forced, so the wake qualifier can restrict which sources may wake the system afterwards.

Top module: `sleep_ctrl`

## Requirements
- R1: After reset, state_o is 2 (soft-off), both sleep outputs are low, wak_sts_o is 0 and reset_type_o is 0.
- R2: The state codes are 0 working, 1 suspend, 2 soft-off and 3 power lost. slp_s4_no is low in codes 1, 2 and 3. slp_s5_no is low in codes 2 and 3. Both outputs are high in code 0.
- R3: slp_typ_wr_i loads the type from slp_typ_i, where 0 selects suspend and 1 selects soft-off. The state changes on the second rising edge after an slp_en_wr_i strobe given in working, and reset_type_o then becomes 0 if the new state is soft-off. An enable strobe given in any other state has no effect.
- R4: If pwrbtn_i is held through HOLD_TICKS rtc ticks in working or suspend, the state becomes soft-off on the edge of the last tick and reset_type_o becomes 1. After HOLD_TICKS-1 ticks the state has not yet changed.
- R5: Releasing the button before HOLD_TICKS ticks gives a one-cycle btn_event_o pulse on the edge after the release, with no change of state. Releasing it after an override gives no pulse.
- R6: thermtrip_i in working gives soft-off on the next edge, with reset_type_o set to 1. In suspend it is ignored.
- R7: wdt_timeout_i or mgmt_shutdown_i in working gives soft-off on the next edge, with reset_type_o set to 0.
- R8: With batlow_i low, a wake_i pulse in suspend or soft-off gives working on the next edge and sets wak_sts_o.
- R9: A wake_i pulse that arrives while batlow_i is high leaves the state unchanged but is latched. The state becomes working on the first edge at which batlow_i is low.
- R10: wak_sts_clr_i clears wak_sts_o. A wake that sets the bit in the same cycle takes priority over the clear.
- R11: pwr_ok_i low gives state 3 on the next edge. All other inputs are ignored while power is lost.
- R12: When power returns with restore_pol_i at 1, the state becomes suspend if suspend was the state at the loss, and soft-off otherwise. A return to soft-off sets reset_type_o to 1.
- R13: When power returns with restore_pol_i at 0, the state becomes working, whatever the state was at the loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rtc_tick_i | input | 1 | One-cycle pulse per RTC tick |
| slp_typ_wr_i | input | 1 | Strobe that loads the sleep type |
| slp_typ_i | input | 1 | Sleep type: 0 suspend, 1 soft-off |
| slp_en_wr_i | input | 1 | Strobe that sets the sleep enable |
| pwrbtn_i | input | 1 | Power button pressed, synchronous, active high |
| thermtrip_i | input | 1 | Thermal trip |
| wdt_timeout_i | input | 1 | Watchdog timeout |
| mgmt_shutdown_i | input | 1 | Management shutdown request |
| wake_i | input | 1 | Qualified wake pulse |
| batlow_i | input | 1 | Battery low, defers wake |
| pwr_ok_i | input | 1 | Main power present |
| restore_pol_i | input | 1 | Policy after power loss: 1 stays off, 0 boots |
| wak_sts_clr_i | input | 1 | Write-1 clear of the wake status |
| state_o | output | 2 | Current power state code |
| slp_s4_no | output | 1 | Suspend-level sleep output, active low |
| slp_s5_no | output | 1 | Soft-off sleep output, active low |
| wak_sts_o | output | 1 | Sticky wake status |
| reset_type_o | output | 1 | Last soft-off entry was forced |
| btn_event_o | output | 1 | Short power-button press pulse |

## Verification
The hardest situation to reach is a wake held back by battery-low. It needs a sleep state, a wake pulse while batlow_i is high, a check that the state did not move, and then the release of batlow_i. The random sequence reaches it from both sleep states by drawing batlow_i at random on each wake. The boundary of the override, one tick short of the threshold against exactly the threshold, is driven by directed cases. The random walk also runs power cycles with both policy values from each of the three states.

// File: rtl/sleep_pkg.sv
package sleep_pkg;
  typedef enum logic [1:0] {
    PS_S0  = 2'd0,
    PS_S4  = 2'd1,
    PS_S5  = 2'd2,
    PS_OFF = 2'd3
  } pstate_e;
endpackage

// File: rtl/slp_btn_hold.sv
module slp_btn_hold #(
  parameter int unsigned HOLD_TICKS = 131072
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic btn_i,
  output logic ovr_o,
  output logic short_o
);
  localparam int unsigned CW = $clog2(HOLD_TICKS + 1);
  localparam logic [CW-1:0] LIM = CW'(HOLD_TICKS);

  logic [CW-1:0] cnt_q;
  logic          btn_q;
  logic          short_q;

  // override fires once, on the tick that completes the hold
  assign ovr_o   = btn_i && tick_i && (cnt_q == LIM - CW'(1));
  assign short_o = short_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      btn_q   <= 1'b0;
      short_q <= 1'b0;
    end else begin
      btn_q   <= btn_i;
      short_q <= btn_q && !btn_i && (cnt_q < LIM);
      if (!btn_i)
        cnt_q <= '0;
      else if (tick_i && cnt_q != LIM)
        cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/slp_wake_gate.sv
module slp_wake_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wake_i,
  input  logic batlow_i,
  input  logic asleep_i,
  output logic go_o
);
  logic pend_q;

  assign go_o = asleep_i && !batlow_i && (wake_i || pend_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pend_q <= 1'b0;
    else if (!asleep_i)          pend_q <= 1'b0;
    else if (wake_i && batlow_i) pend_q <= 1'b1;
  end
endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
  import sleep_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    pwr_ok_i,
  input  logic    restore_pol_i,
  input  logic    typ_wr_i,
  input  logic    typ_i,
  input  logic    en_wr_i,
  input  logic    ovr_i,
  input  logic    therm_i,
  input  logic    soft_kill_i,
  input  logic    go_i,
  input  logic    sts_clr_i,
  output pstate_e st_o,
  output logic    rst_type_o,
  output logic    wak_sts_o
);
  pstate_e st_q, st_d, saved_q;
  logic    rt_q, rt_d;
  logic    wak_q, wake_set;
  logic    typ_q, en_q;

  always_comb begin
    st_d     = st_q;
    rt_d     = rt_q;
    wake_set = 1'b0;
    if (!pwr_ok_i) begin
      st_d = PS_OFF;
    end else begin
      unique case (st_q)
        PS_S0: begin
          if (therm_i || ovr_i) begin
            st_d = PS_S5; rt_d = 1'b1;
          end else if (soft_kill_i) begin
            st_d = PS_S5; rt_d = 1'b0;
          end else if (en_q) begin
            st_d = typ_q ? PS_S5 : PS_S4;
            if (typ_q) rt_d = 1'b0;
          end
        end
        PS_S4: begin
          if (ovr_i) begin
            st_d = PS_S5; rt_d = 1'b1;
          end else if (go_i) begin
            st_d = PS_S0; wake_set = 1'b1;
          end
        end
        PS_S5: begin
          if (go_i) begin
            st_d = PS_S0; wake_set = 1'b1;
          end
        end
        default: begin
          if (!restore_pol_i) begin
            st_d = PS_S0;
          end else if (saved_q == PS_S4) begin
            st_d = PS_S4;
          end else begin
            st_d = PS_S5; rt_d = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= PS_S5;
      saved_q <= PS_S5;
      rt_q    <= 1'b0;
      wak_q   <= 1'b0;
      typ_q   <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      st_q <= st_d;
      rt_q <= rt_d;
      if (!pwr_ok_i && st_q != PS_OFF) saved_q <= st_q;
      if (wake_set)       wak_q <= 1'b1;
      else if (sts_clr_i) wak_q <= 1'b0;
      if (typ_wr_i) typ_q <= typ_i;
      // enable is honoured in S0 only and clears once the move starts
      if (st_q != PS_S0 || en_q) en_q <= 1'b0;
      else if (en_wr_i)          en_q <= 1'b1;
    end
  end

  assign st_o       = st_q;
  assign rst_type_o = rt_q;
  assign wak_sts_o  = wak_q;
endmodule

// File: rtl/sleep_ctrl.sv
module sleep_ctrl
  import sleep_pkg::*;
#(
  parameter int unsigned HOLD_TICKS = 131072
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rtc_tick_i,
  input  logic       slp_typ_wr_i,
  input  logic       slp_typ_i,
  input  logic       slp_en_wr_i,
  input  logic       pwrbtn_i,
  input  logic       thermtrip_i,
  input  logic       wdt_timeout_i,
  input  logic       mgmt_shutdown_i,
  input  logic       wake_i,
  input  logic       batlow_i,
  input  logic       pwr_ok_i,
  input  logic       restore_pol_i,
  input  logic       wak_sts_clr_i,
  output logic [1:0] state_o,
  output logic       slp_s4_no,
  output logic       slp_s5_no,
  output logic       wak_sts_o,
  output logic       reset_type_o,
  output logic       btn_event_o
);
  logic    ovr, go;
  pstate_e st;

  slp_btn_hold #(.HOLD_TICKS(HOLD_TICKS)) u_btn (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (rtc_tick_i),
    .btn_i   (pwrbtn_i),
    .ovr_o   (ovr),
    .short_o (btn_event_o)
  );

  slp_wake_gate u_wake (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wake_i   (wake_i),
    .batlow_i (batlow_i),
    .asleep_i (st == PS_S4 || st == PS_S5),
    .go_o     (go)
  );

  slp_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pwr_ok_i      (pwr_ok_i),
    .restore_pol_i (restore_pol_i),
    .typ_wr_i      (slp_typ_wr_i),
    .typ_i         (slp_typ_i),
    .en_wr_i       (slp_en_wr_i),
    .ovr_i         (ovr),
    .therm_i       (thermtrip_i),
    .soft_kill_i   (wdt_timeout_i || mgmt_shutdown_i),
    .go_i          (go),
    .sts_clr_i     (wak_sts_clr_i),
    .st_o          (st),
    .rst_type_o    (reset_type_o),
    .wak_sts_o     (wak_sts_o)
  );

  assign state_o   = st;
  assign slp_s4_no = (st == PS_S0);
  assign slp_s5_no = (st == PS_S0) || (st == PS_S4);
endmodule

// File: rtl/sleep_ctrl_chk.sv
module sleep_ctrl_chk
  import sleep_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pwr_ok_i,
  input logic       batlow_i,
  input logic       thermtrip_i,
  input logic       restore_pol_i,
  input logic [1:0] state_o,
  input logic       slp_s4_no,
  input logic       slp_s5_no,
  input logic       wak_sts_o,
  input logic       reset_type_o,
  input logic       btn_event_o
);
  // R2
  s5_implies_s4_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slp_s5_no |-> !slp_s4_no);

  // R11
  pwr_loss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_ok_i |=> state_o == PS_OFF);

  // R6
  therm_trip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == PS_S0 && thermtrip_i && pwr_ok_i) |=> (state_o == PS_S5 && reset_type_o));

  // R9
  batlow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_o == PS_S4 || state_o == PS_S5) && batlow_i && pwr_ok_i) |=> state_o != PS_S0);

  // R8
  wake_sets_sts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(state_o) == PS_S4 || $past(state_o) == PS_S5) && state_o == PS_S0) |-> wak_sts_o);

  // R13
  restore_boot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == PS_OFF && pwr_ok_i && !restore_pol_i) |=> state_o == PS_S0);

  // R5
  btn_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    btn_event_o |=> !btn_event_o);
endmodule

bind sleep_ctrl sleep_ctrl_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .pwr_ok_i      (pwr_ok_i),
  .batlow_i      (batlow_i),
  .thermtrip_i   (thermtrip_i),
  .restore_pol_i (restore_pol_i),
  .state_o       (state_o),
  .slp_s4_no     (slp_s4_no),
  .slp_s5_no     (slp_s5_no),
  .wak_sts_o     (wak_sts_o),
  .reset_type_o  (reset_type_o),
  .btn_event_o   (btn_event_o)
);

// File: tb/sleep_ctrl_tb.sv
`timescale 1ns/1ps
module sleep_ctrl_tb;
  localparam int unsigned HOLD = 8;
  localparam logic [1:0] S0 = 2'd0, S4 = 2'd1, S5 = 2'd2, OFF = 2'd3;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic rtc_tick_i = 0, slp_typ_wr_i = 0, slp_typ_i = 0, slp_en_wr_i = 0;
  logic pwrbtn_i = 0, thermtrip_i = 0, wdt_timeout_i = 0, mgmt_shutdown_i = 0;
  logic wake_i = 0, batlow_i = 0, pwr_ok_i = 1, restore_pol_i = 0, wak_sts_clr_i = 0;
  logic [1:0] state_o;
  logic slp_s4_no, slp_s5_no, wak_sts_o, reset_type_o, btn_event_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [1:0] e_st = S5, e_saved = S5;
  logic e_wak = 0, e_rt = 0;

  always #2 clk_i = ~clk_i;

  sleep_ctrl #(.HOLD_TICKS(HOLD)) u_dut (.*);

  function automatic logic [5:0] exp_vec(logic [1:0] st, logic wak, logic rt);
    return {st, st == S0, (st == S0) || (st == S4), wak, rt};
  endfunction

  function automatic logic [1:0] exp_restore(logic [1:0] prior, logic pol);
    if (!pol) return S0;
    return (prior == S4) ? S4 : S5;
  endfunction

  task automatic step();
    @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic check(string req);
    logic [5:0] act, exp;
    act = {state_o, slp_s4_no, slp_s5_no, wak_sts_o, reset_type_o};
    exp = exp_vec(e_st, e_wak, e_rt);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {st,s4n,s5n,wak,rt} act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic check_bit(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic sw_sleep(logic typ);
    slp_typ_wr_i = 1; slp_typ_i = typ; step();
    slp_typ_wr_i = 0; slp_en_wr_i = 1; step();
    slp_en_wr_i = 0;
    check("R3 no move one edge after enable");
    step();
    if (e_st == S0) begin
      e_st = typ ? S5 : S4;
      if (typ) e_rt = 0;
    end
    check("R3 software sleep");
  endtask

  task automatic pulse_therm();
    thermtrip_i = 1; step(); thermtrip_i = 0;
    if (e_st == S0) begin e_st = S5; e_rt = 1; end
    check("R6 thermal trip");
  endtask

  task automatic pulse_kill(bit use_mgmt);
    if (use_mgmt) mgmt_shutdown_i = 1; else wdt_timeout_i = 1;
    step(); mgmt_shutdown_i = 0; wdt_timeout_i = 0;
    if (e_st == S0) begin e_st = S5; e_rt = 0; end
    check("R7 watchdog or management shutdown");
  endtask

  task automatic hold_btn(int unsigned ticks);
    pwrbtn_i = 1;
    for (int i = 0; i < ticks; i++) begin
      rtc_tick_i = 1; step(); rtc_tick_i = 0; step();
    end
  endtask

  task automatic override();
    hold_btn(HOLD - 1);
    check("R4 no override one tick short");
    rtc_tick_i = 1; step(); rtc_tick_i = 0;
    if (e_st != S5) begin e_st = S5; e_rt = 1; end
    check("R4 override");
    pwrbtn_i = 0; step();
    check_bit("R5 no pulse after override", btn_event_o, 1'b0);
  endtask

  task automatic short_press();
    hold_btn(3);
    pwrbtn_i = 0; step();
    check_bit("R5 short press pulse", btn_event_o, 1'b1);
    step();
    check_bit("R5 pulse lasts one cycle", btn_event_o, 1'b0);
    check("R5 no state change on short press");
  endtask

  task automatic wake(bit bl);
    logic asleep;
    asleep = (e_st == S4 || e_st == S5);
    if (bl) begin
      batlow_i = 1; wake_i = 1; step(); wake_i = 0; step();
      check("R9 wake deferred by battery low");
      batlow_i = 0; step();
      if (asleep) begin e_st = S0; e_wak = 1; end
      check("R9 latched wake taken");
    end else begin
      wake_i = 1; step(); wake_i = 0;
      if (asleep) begin e_st = S0; e_wak = 1; end
      check("R8 wake");
    end
  endtask

  task automatic power_cycle(logic pol);
    pwr_ok_i = 0; wake_i = 1; thermtrip_i = 1; step();
    wake_i = 0; thermtrip_i = 0;
    if (e_st != OFF) e_saved = e_st;
    e_st = OFF;
    check("R11 power lost");
    step();
    check("R11 inputs ignored while power lost");
    restore_pol_i = pol; pwr_ok_i = 1; step();
    e_st = exp_restore(e_saved, pol);
    if (e_st == S5) e_rt = 1;
    check(pol ? "R12 restore policy 1" : "R13 restore policy 0");
  endtask

  task automatic clr_sts();
    wak_sts_clr_i = 1; step(); wak_sts_clr_i = 0;
    e_wak = 0;
    check("R10 wake status clear");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    check("R1 reset state");
    check_bit("R2 soft-off s4 low", slp_s4_no, 1'b0);

    slp_en_wr_i = 1; step(); slp_en_wr_i = 0; step();
    check("R3 enable outside S0 ignored");

    // set has priority over clear
    wake_i = 1; wak_sts_clr_i = 1; step(); wake_i = 0; wak_sts_clr_i = 0;
    e_st = S0; e_wak = 1;
    check("R10 set wins over clear");
    clr_sts();

    wake(0);
    check("R8 wake in S0 ignored");
    short_press();
    sw_sleep(0);
    check_bit("R2 suspend s5 high", slp_s5_no, 1'b1);
    pulse_therm();
    check("R6 ignored in suspend");
    override();
    wake(1);
    pulse_kill(0);
    wake(0);
    power_cycle(1);
    wake(0);
    sw_sleep(0);
    power_cycle(1);
    power_cycle(0);

    void'($urandom(32'd4242));
    for (int it = 0; it < 60; it++) begin
      int op;
      op = int'($urandom % 7);
      if (e_st == S0) begin
        case (op)
          0: sw_sleep(1'($urandom));
          1: pulse_therm();
          2: pulse_kill(1'($urandom));
          3: override();
          4: power_cycle(1'($urandom));
          5: short_press();
          default: clr_sts();
        endcase
      end else begin
        case (op)
          0, 1: wake(1'($urandom));
          2: power_cycle(1'($urandom));
          3: override();
          4: pulse_therm();
          5: sw_sleep(1'($urandom));
          default: clr_sts();
        endcase
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule